// File: doc/BRIEF.md
# Configurable SRAM bus cycle sequencer

This block times one access to an external static RAM on a single chip select. A requester presents an address, a direction, byte enables and write data. The block then drives chip select, address, read strobe, per-byte write enables and a read/write direction pin in a fixed sequence: a setup phase, a strobe phase, and a short hold. At the end it raises a one-cycle done pulse. On reads it also returns the data it captured from the bus.

The sequencer runs on a clock at twice the bus rate, so each tick is half a bus cycle. Setup delays of 0.5 to 3.5 bus cycles therefore become whole tick counts. A control register sets the setup delay, a read wait count, and a write wait count that can fall back to the read count. It also holds a byte-mode bit. That bit chooses whether the write enables pulse at the strobe while the direction pin covers the whole write, or the write enables cover the whole access as byte selects while the direction pin pulses. The timing of an access is fixed when the request is accepted.

Top module: `sram_cycle_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, chip select, read strobe and all write enables are high (inactive), the direction pin is high, the data output enable is low, done is low and req_ready is high. The control register resets to 0.
- R2: The control register fields are: setup code at bits [1:0], read wait at bits [5:2], write wait code at bits [8:6], byte mode at bit 12. All other bits read back as 0 whatever is written.
- R3: From the first tick with chip select low to the first tick of the strobe there are 2*setup+1 ticks.
- R4: A read strobe lasts 2*(1+W) ticks, where W is the read wait field saturated at 6.
- R5: A write strobe lasts 2*(1+W) ticks. Write wait code 0 sets W to the saturated read wait. Codes 1 to 7 set W to code-1.
- R6: After the strobe ends, chip select and address stay driven for exactly one tick. done is high for that tick only, and chip select goes high on the next tick.
- R7: A read returns on rd_data, valid while done is high, the bus_din value present in the last strobe tick.
- R8: With byte mode 0, a write drives bus_we_n to the inverse of the byte enables during the strobe only and holds bus_rdwr low for the whole access. A read leaves bus_we_n high and bus_rdwr high.
- R9: With byte mode 1, bus_we_n equals the inverse of the byte enables for the whole access in both directions. On writes bus_rdwr is low only during the strobe, and on reads it stays high.
- R10: A request is accepted only when req_ready is high, which is only in idle. A request raised during an access is ignored and starts no later access.
- R11: A control register write during an access does not change that access. It takes effect from the next accepted request.
- R12: During a write, bus_dout carries the request's write data and bus_doe is high for every tick with chip select low. During a read, bus_doe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, twice the bus rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write value |
| cfg_rdata | output | CFG_W | Control register read value |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| req_ready | output | 1 | High when idle and able to accept |
| done | output | 1 | One-tick pulse at the end of an access |
| rd_data | output | DATA_W | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | DATA_W/8 | Per-byte write enables, active low |
| bus_rdwr | output | 1 | Direction, low for write |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | Read data from the bus |

## Verification
The assertions check on every cycle that the pins stay quiet while chip select is high, that done lasts one tick and is followed by idle, that a read strobe falls only after chip select has been low, and that a read never coexists with a write direction or driven data. Only the bench scenarios can show the tick counts of setup, strobe and hold for each code, the write-wait fallback and read-wait saturation, and which strobe covers the whole access in each byte mode. The same holds for the tick on which read data is sampled, and for the config snapshot taken when a request is accepted.

// File: rtl/sram_seq_pkg.sv
// Package: shared types and control register layout for the SRAM sequencer.
// Assumes the register is at least 13 bits wide.
package sram_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;

    localparam int SU_LSB = 0;
    localparam int SU_W   = 2;
    localparam int RW_LSB = 2;
    localparam int RW_W   = 4;
    localparam int WW_LSB = 6;
    localparam int WW_W   = 3;
    localparam int BM_BIT = 12;

    typedef struct packed {
        logic            byte_mode;
        logic [WW_W-1:0] wr_wait;
        logic [RW_W-1:0] rd_wait;
        logic [SU_W-1:0] setup;
    } seq_cfg_t;
endpackage

// File: rtl/sram_cfg_reg.sv
// Control register: holds setup, read wait, write wait and byte mode fields.
// Reserved bits are never stored, so they always read as 0.
module sram_cfg_reg
    import sram_seq_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output seq_cfg_t         cfg
);
    localparam logic [CFG_W-1:0] KEEP_MASK =
        (CFG_W'((1 << SU_W) - 1) << SU_LSB) |
        (CFG_W'((1 << RW_W) - 1) << RW_LSB) |
        (CFG_W'((1 << WW_W) - 1) << WW_LSB) |
        (CFG_W'(1) << BM_BIT);

    logic [CFG_W-1:0] store_q;

    // Store writable bits only; reset to all zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (wr_en)
            store_q <= wdata & KEEP_MASK;
    end

    // Present register value and decoded fields.
    always_comb begin
        rdata         = store_q;
        cfg.setup     = store_q[SU_LSB +: SU_W];
        cfg.rd_wait   = store_q[RW_LSB +: RW_W];
        cfg.wr_wait   = store_q[WW_LSB +: WW_W];
        cfg.byte_mode = store_q[BM_BIT];
    end
endmodule

// File: rtl/sram_timing_calc.sv
// Timing decode: turns register codes and direction into tick counts at the
// double-rate clock. Setup = 2*code+1; strobe = 2*(1+wait). Read wait saturates
// at MAX_WAIT; write code 0 falls back to the read wait.
module sram_timing_calc
    import sram_seq_pkg::*;
#(
    parameter int MAX_WAIT = 6,
    parameter int CNT_W    = 4
) (
    input  seq_cfg_t         cfg,
    input  logic             is_write,
    output logic [CNT_W-1:0] setup_ticks,
    output logic [CNT_W-1:0] strobe_ticks
);
    logic [CNT_W-1:0] rd_wait_sat;
    logic [CNT_W-1:0] wait_sel;

    // Derive wait count and tick lengths.
    always_comb begin
        rd_wait_sat = (int'(cfg.rd_wait) > MAX_WAIT) ? CNT_W'(MAX_WAIT) : CNT_W'(cfg.rd_wait);
        if (!is_write || cfg.wr_wait == '0)
            wait_sel = rd_wait_sat;
        else
            wait_sel = CNT_W'(cfg.wr_wait) - CNT_W'(1);
        setup_ticks  = (CNT_W'(cfg.setup) << 1) + CNT_W'(1);
        strobe_ticks = (wait_sel + CNT_W'(1)) << 1;
    end
endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: IDLE -> SETUP -> STROBE -> HOLD -> IDLE. Tick counts are
// latched at acceptance so later register writes do not affect the access.
// Assumes setup_ticks and strobe_ticks are at least 1.
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] setup_ticks,
    input  logic [CNT_W-1:0] strobe_ticks,
    output seq_state_t       state,
    output logic             last_strobe
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] strobe_len_q;

    // Advance phase when the per-phase counter reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cnt_q        <= '0;
            strobe_len_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state        <= ST_SETUP;
                    cnt_q        <= setup_ticks - CNT_W'(1);
                    strobe_len_q <= strobe_ticks;
                end
                ST_SETUP: if (cnt_q == '0) begin
                    state <= ST_STROBE;
                    cnt_q <= strobe_len_q - CNT_W'(1);
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_STROBE: if (cnt_q == '0) begin
                    state <= ST_HOLD;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Flag the final strobe tick for read capture.
    always_comb last_strobe = (state == ST_STROBE) && (cnt_q == '0);
endmodule

// File: rtl/sram_pin_drive.sv
// Pin decode: maps phase, direction and byte mode to the strobe pins.
// Mode 0: write enables pulse in the strobe, direction covers the write.
// Mode 1: write enables act as byte selects for the whole access,
// direction pulses in the write strobe.
module sram_pin_drive
    import sram_seq_pkg::*;
#(
    parameter int NB = 2
) (
    input  seq_state_t    state,
    input  logic          is_write,
    input  logic          byte_mode,
    input  logic [NB-1:0] be,
    output logic          cs_n,
    output logic          rd_n,
    output logic [NB-1:0] we_n,
    output logic          rdwr,
    output logic          doe
);
    logic active;
    logic strobe;

    // Phase flags shared by all pins.
    always_comb begin
        active = (state != ST_IDLE);
        strobe = (state == ST_STROBE);
        cs_n   = !active;
        rd_n   = !(strobe && !is_write);
        doe    = active && is_write;
        if (byte_mode)
            rdwr = !(strobe && is_write);
        else
            rdwr = !(active && is_write);
    end

    // Per-lane write enable selection.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        always_comb begin
            if (byte_mode)
                we_n[g] = !(active && be[g]);
            else
                we_n[g] = !(strobe && is_write && be[g]);
        end
    end
endmodule

// File: rtl/sram_cycle_seq.sv
// Top: one-chip-select SRAM access sequencer on a double-rate clock.
// Accepts a request in idle, snapshots request and mode, runs the phase
// sequence and returns done (and read data) in the hold tick.
module sram_cycle_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int CFG_W    = 16,
    parameter int MAX_WAIT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                req_ready,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data,
    output logic                bus_cs_n,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_rd_n,
    output logic [DATA_W/8-1:0] bus_we_n,
    output logic                bus_rdwr,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_doe,
    input  logic [DATA_W-1:0]   bus_din
);
    localparam int NB    = DATA_W / 8;
    localparam int CNT_W = $clog2(2 * (MAX_WAIT + 1) + 1);

    seq_cfg_t         cfg;
    seq_state_t       state;
    logic             last_strobe;
    logic             accept;
    logic [CNT_W-1:0] setup_ticks;
    logic [CNT_W-1:0] strobe_ticks;

    logic              wr_q;
    logic              mode_q;
    logic [NB-1:0]     be_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    sram_cfg_reg #(.CFG_W(CFG_W)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    sram_timing_calc #(.MAX_WAIT(MAX_WAIT), .CNT_W(CNT_W)) calc_i (
        .cfg          (cfg),
        .is_write     (req_write),
        .setup_ticks  (setup_ticks),
        .strobe_ticks (strobe_ticks)
    );

    sram_seq_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept),
        .setup_ticks  (setup_ticks),
        .strobe_ticks (strobe_ticks),
        .state        (state),
        .last_strobe  (last_strobe)
    );

    sram_pin_drive #(.NB(NB)) pins_i (
        .state     (state),
        .is_write  (wr_q),
        .byte_mode (mode_q),
        .be        (be_q),
        .cs_n      (bus_cs_n),
        .rd_n      (bus_rd_n),
        .we_n      (bus_we_n),
        .rdwr      (bus_rdwr),
        .doe       (bus_doe)
    );

    // Handshake and status decode.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
        done      = (state == ST_HOLD);
        bus_addr  = addr_q;
        bus_dout  = wdata_q;
        rd_data   = rdata_q;
    end

    // Snapshot request and byte mode at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            mode_q  <= 1'b0;
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            mode_q  <= cfg.byte_mode;
            be_q    <= req_be;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture read data at the end of the last strobe tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (last_strobe && !wr_q)
            rdata_q <= bus_din;
    end
endmodule

// File: rtl/sram_cycle_seq_chk.sv
// Checker: cycle-level protocol properties of the sequencer pins.
module sram_cycle_seq_chk #(
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cs_n,
    input logic          bus_rd_n,
    input logic [NB-1:0] bus_we_n,
    input logic          bus_rdwr,
    input logic          bus_doe,
    input logic          done,
    input logic          req_ready
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> (bus_rd_n && (&bus_we_n) && bus_rdwr && !bus_doe && !done));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> bus_cs_n);

    // R3
    setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> $past(!bus_cs_n));

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_cs_n);

    // R12
    read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (bus_rdwr && !bus_doe));
endmodule

bind sram_cycle_seq sram_cycle_seq_chk #(.NB(NB)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_we_n  (bus_we_n),
    .bus_rdwr  (bus_rdwr),
    .bus_doe   (bus_doe),
    .done      (done),
    .req_ready (req_ready)
);

// File: tb/sram_cycle_seq_tb.sv
// Directed bench for sram_cycle_seq: one task per scenario.
module sram_cycle_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, done;
    logic [15:0] rd_data;
    logic        bus_cs_n, bus_rd_n, bus_rdwr, bus_doe;
    logic [15:0] bus_addr, bus_dout, bus_din;
    logic [1:0]  bus_we_n;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;
    always_ff @(posedge clk) cyc <= cyc + 1;
    assign bus_din = 16'(cyc) ^ 16'h5A3C;

    sram_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
        .bus_we_n(bus_we_n), .bus_rdwr(bus_rdwr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_cfg(input int su, input int rw, input int ww, input int bm);
        return 16'((bm << 12) | (ww << 6) | (rw << 2) | su);
    endfunction

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access with full measurement against expected tick counts.
    task automatic do_access(input bit wr, input logic [15:0] addr, input logic [15:0] wdata,
                             input logic [1:0] be, input int su_exp, input int strb_exp,
                             input bit mode, input string tag);
        int n_setup = 0, n_strobe = 0, n_hold = 0, n_done = 0, bad_pin = 0, last_c = 0, n = 0;
        bit strobe_seen = 0, strobe_now;
        logic [15:0] rd_seen = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wdata; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        while (!bus_cs_n && n < 64) begin
            if (wr) strobe_now = mode ? !bus_rdwr : (bus_we_n != 2'b11);
            else    strobe_now = !bus_rd_n;
            if (strobe_now) begin
                n_strobe++; strobe_seen = 1; last_c = cyc;
            end else if (strobe_seen) n_hold++;
            else n_setup++;
            if (done) begin
                n_done++;
                rd_seen = rd_data;
                if (strobe_now || !strobe_seen) bad_pin++;
            end
            if (bus_addr != addr) bad_pin++;
            if (wr && (bus_dout != wdata || !bus_doe)) bad_pin++;
            if (!wr && bus_doe) bad_pin++;
            if (wr && !bus_rd_n) bad_pin++;
            if (mode) begin
                if (bus_we_n != ~be) bad_pin++;
                if (!wr && !bus_rdwr) bad_pin++;
            end else begin
                if (wr && bus_rdwr) bad_pin++;
                if (!wr && (!bus_rdwr || bus_we_n != 2'b11)) bad_pin++;
                if (wr && strobe_now && bus_we_n != ~be) bad_pin++;
            end
            @(negedge clk);
            n++;
        end
        check(n_setup == su_exp, "R3", {tag, " setup ticks"}, n_setup, su_exp);
        check(n_strobe == strb_exp, wr ? "R5" : "R4", {tag, " strobe ticks"}, n_strobe, strb_exp);
        check(n_hold == 1 && n_done == 1, "R6", {tag, " hold/done ticks"}, n_hold * 10 + n_done, 11);
        check(bad_pin == 0, mode ? "R9" : "R8", {tag, " pin pattern (also R12 data)"}, bad_pin, 0);
        if (!wr)
            check(rd_seen == (16'(last_c) ^ 16'h5A3C), "R7", {tag, " read data"},
                  int'(rd_seen), int'(16'(last_c) ^ 16'h5A3C));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(bus_cs_n && bus_rd_n && bus_we_n == 2'b11 && bus_rdwr && !bus_doe,
              "R1", "idle pins", int'({bus_cs_n, bus_rd_n, bus_we_n, bus_rdwr, bus_doe}), 6'b111110);
        check(req_ready && !done, "R1", "ready/done", int'({req_ready, done}), 2'b10);
        check(cfg_rdata == 16'h0, "R1", "cfg reset value", int'(cfg_rdata), 0);
    endtask

    task automatic t_cfg_reserved;
        write_cfg(16'hFFFF);
        @(negedge clk);
        check(cfg_rdata == 16'h11FF, "R2", "reserved bits read 0", int'(cfg_rdata), 16'h11FF);
        write_cfg(16'hEE00);
        @(negedge clk);
        check(cfg_rdata == 16'h0000, "R2", "reserved-only write", int'(cfg_rdata), 0);
    endtask

    task automatic t_read_timing;
        int rw_codes[4] = '{0, 3, 6, 9};
        for (int s = 0; s < 4; s++) begin
            int w = (rw_codes[s] > 6) ? 6 : rw_codes[s];
            write_cfg(mk_cfg(s, rw_codes[s], 0, 0));
            do_access(0, 16'h1000 + 16'(s), 16'h0, 2'b11, 2 * s + 1, 2 * (1 + w), 0, "read");
        end
    endtask

    task automatic t_write_wait;
        for (int c = 0; c < 8; c++) begin
            int w = (c == 0) ? 4 : c - 1;
            write_cfg(mk_cfg(1, 4, c, 0));
            do_access(1, 16'h2000 + 16'(c), 16'hA000 + 16'(c), 2'b11, 3, 2 * (1 + w), 0, "write wait");
        end
        write_cfg(mk_cfg(0, 12, 0, 0));
        do_access(1, 16'h2100, 16'hBEEF, 2'b11, 1, 14, 0, "write fallback saturated");
    endtask

    task automatic t_byte_modes;
        write_cfg(mk_cfg(0, 1, 2, 0));
        do_access(1, 16'h3000, 16'h1234, 2'b01, 1, 4, 0, "mode0 write low lane");
        do_access(0, 16'h3002, 16'h0, 2'b10, 1, 4, 0, "mode0 read");
        write_cfg(mk_cfg(2, 1, 3, 1));
        do_access(1, 16'h3004, 16'h5678, 2'b10, 5, 6, 1, "mode1 write");
        do_access(0, 16'h3006, 16'h0, 2'b01, 5, 4, 1, "mode1 read");
    endtask

    task automatic t_cfg_snapshot;
        write_cfg(mk_cfg(0, 0, 0, 0));
        fork
            do_access(0, 16'h4000, 16'h0, 2'b11, 1, 2, 0, "R11 old cfg");
            write_cfg(mk_cfg(3, 2, 0, 1));
        join
        do_access(0, 16'h4002, 16'h0, 2'b11, 7, 6, 1, "R11 new cfg");
    endtask

    task automatic t_busy_ignore;
        int extra = 0;
        write_cfg(mk_cfg(1, 3, 0, 0));
        fork
            do_access(0, 16'h5000, 16'h0, 2'b11, 3, 8, 0, "busy");
            begin
                repeat (4) @(negedge clk);
                check(!req_ready, "R10", "ready low during access", int'(req_ready), 0);
                req_valid = 1'b1; req_addr = 16'h5555; req_write = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        for (int i = 0; i < 6; i++) begin
            if (!bus_cs_n) extra++;
            @(negedge clk);
        end
        check(extra == 0 && req_ready, "R10", "no access from busy request", extra, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg_reserved();
        t_read_timing();
        t_write_wait();
        t_byte_modes();
        t_cfg_snapshot();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule